// File: doc/BRIEF.md
# Pipelined Burst SRAM Core

This block is a synchronous single-port memory with a 32-bit word split into four byte lanes, with a small depth set by a parameter. On each rising clock edge it captures the address, three chip selects, two burst-start strobes, the advance control, the write controls and the write data. In the following cycle it classifies that captured cycle as an idle, deselect, burst start, burst continue or burst suspend cycle. It then performs the read or the byte-masked write. Read data passes through an output register.

Either of two strobes can start a burst. The processor-side strobe only counts while the primary active-low select is low, and it always starts a read. The controller-side strobe starts a read or a write, depending on the captured write controls. If either strobe is taken while the three selects do not all agree, the cycle becomes a deselect. A 2-bit burst counter steps the low address bits in either linear or interleaved order. An asynchronous output enable and an asynchronous sleep input gate the bus drive.

Top module: `burst_sram_core`

## Requirements
- R1: The device counts as selected only when `cs_n_i`=0, `cs2_n_i`=0 and `cs2_i`=1. A start strobe taken while it is not selected is a deselect. The bus is not driven after the deselect executes, and later advance cycles access nothing until a new burst starts.
- R2: `start_proc_n_i` is ignored while `cs_n_i`=1. In that case a running burst proceeds as if the strobe were high. With `cs_n_i`=0 and the device selected, the strobe loads the address and starts a read, even when the write controls request a write.
- R3: With `start_proc_n_i` not taken, `start_ctrl_n_i`=0 on a selected device loads the address. It starts a write if a write is requested and a read otherwise.
- R4: With both strobes high during a burst, `adv_n_i`=0 advances the 2-bit burst offset and `adv_n_i`=1 repeats the current address. The upper address bits stay at the loaded value. With `burst_linear_i`=1 the low two bits are (start+n) mod 4. With `burst_linear_i`=0 they are start XOR n.
- R5: A write is requested when `wr_all_n_i`=0, or when `wr_lane_en_n_i`=0 and some `lane_n_i` bit is 0. `wr_all_n_i`=0 writes all four bytes. Otherwise `lane_n_i[k]`=0 writes bits 8k+7:8k. With `wr_lane_en_n_i`=1 the lane bits have no effect and the cycle is a read.
- R6: After a read started by `start_proc_n_i`, a continue or suspend cycle with a write request writes the current burst address.
- R7: Data for a read captured at edge E is on `dq_o` with `dq_en_o`=1 after edge E+1. Burst beats follow on every cycle after that.
- R8: `oe_n_i`=1 forces `dq_en_o`=0 at once, without a clock edge, and does not disturb the pipeline.
- R9: `dq_en_o` is 0 after reset and after a write executes.
- R10: `sleep_i`=1 forces `dq_en_o`=0 at once. Cycles captured while it is high access nothing.
- R11: A read captured on the cycle right after a write to the same address returns the newly written bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Word address |
| cs_n_i | input | 1 | Primary select, active low, also qualifies the processor strobe |
| cs2_n_i | input | 1 | Second select, active low |
| cs2_i | input | 1 | Third select, active high |
| start_proc_n_i | input | 1 | Processor-side burst start, active low, read only |
| start_ctrl_n_i | input | 1 | Controller-side burst start, active low |
| adv_n_i | input | 1 | Burst advance, active low; high suspends |
| wr_all_n_i | input | 1 | Full-word write, active low |
| wr_lane_en_n_i | input | 1 | Enables the byte-lane write bits, active low |
| lane_n_i | input | LANES | Per-lane write, active low |
| wdata_i | input | DATA_W | Write data |
| burst_linear_i | input | 1 | 1 selects linear order, 0 selects interleaved order |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Asynchronous standby, active high |
| dq_o | output | DATA_W | Read data (zero when not driven) |
| dq_en_o | output | 1 | Bus drive enable |

## Verification
A captured cycle executes one edge later, so its result is due after the second rising edge. The bench drives inputs on falling edges and samples on the falling edge that follows the executing edge. In a burst, each sample therefore shows the beat of the step before. Output enable and sleep act without a clock edge, so those checks sample a nanosecond after the level change within the same low phase. Writes and ignored strobes are confirmed through a later read of the affected addresses.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

   typedef enum logic [2:0] {
      CYC_IDLE  = 3'd0,
      CYC_DESEL = 3'd1,
      CYC_START = 3'd2,
      CYC_CONT  = 3'd3,
      CYC_SUSP  = 3'd4
   } cyc_e;

   localparam int LANE_BITS = 8;

endpackage

// File: rtl/sbm_capture.sv
module sbm_capture #(
   parameter int ADDR_W = 4,
   parameter int LANES  = 4,
   localparam int DW    = LANES * sbm_pkg::LANE_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              cs_n_i,
   input  logic              cs2_n_i,
   input  logic              cs2_i,
   input  logic              start_proc_n_i,
   input  logic              start_ctrl_n_i,
   input  logic              adv_n_i,
   input  logic              wr_all_n_i,
   input  logic              wr_lane_en_n_i,
   input  logic [LANES-1:0]  lane_n_i,
   input  logic [DW-1:0]     wdata_i,
   input  logic              sleep_i,
   output logic [ADDR_W-1:0] addr_q,
   output logic              cs_n_q,
   output logic              cs2_n_q,
   output logic              cs2_q,
   output logic              start_proc_n_q,
   output logic              start_ctrl_n_q,
   output logic              adv_n_q,
   output logic              wr_all_n_q,
   output logic              wr_lane_en_n_q,
   output logic [LANES-1:0]  lane_n_q,
   output logic [DW-1:0]     wdata_q,
   output logic              sleep_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q         <= '0;
         cs_n_q         <= 1'b1;
         cs2_n_q        <= 1'b1;
         cs2_q          <= 1'b0;
         start_proc_n_q <= 1'b1;
         start_ctrl_n_q <= 1'b1;
         adv_n_q        <= 1'b1;
         wr_all_n_q     <= 1'b1;
         wr_lane_en_n_q <= 1'b1;
         lane_n_q       <= '1;
         wdata_q        <= '0;
         sleep_q        <= 1'b0;
      end else begin
         addr_q         <= addr_i;
         cs_n_q         <= cs_n_i;
         cs2_n_q        <= cs2_n_i;
         cs2_q          <= cs2_i;
         start_proc_n_q <= start_proc_n_i;
         start_ctrl_n_q <= start_ctrl_n_i;
         adv_n_q        <= adv_n_i;
         wr_all_n_q     <= wr_all_n_i;
         wr_lane_en_n_q <= wr_lane_en_n_i;
         lane_n_q       <= lane_n_i;
         wdata_q        <= wdata_i;
         sleep_q        <= sleep_i;
      end
   end

endmodule

// File: rtl/sbm_cycle_decode.sv
module sbm_cycle_decode #(
   parameter int LANES = 4
) (
   input  logic              sleep_q,
   input  logic              cs_n_q,
   input  logic              cs2_n_q,
   input  logic              cs2_q,
   input  logic              start_proc_n_q,
   input  logic              start_ctrl_n_q,
   input  logic              adv_n_q,
   input  logic              wr_all_n_q,
   input  logic              wr_lane_en_n_q,
   input  logic [LANES-1:0]  lane_n_q,
   input  logic              active_i,
   output sbm_pkg::cyc_e     cyc_o,
   output logic              wr_o,
   output logic              rd_o,
   output logic [LANES-1:0]  lane_we_o
);
   import sbm_pkg::*;

   logic selected, proc_go, wreq;
   logic [LANES-1:0] lane_sel;

   always_comb begin
      selected = !cs_n_q && !cs2_n_q && cs2_q;
      proc_go  = !start_proc_n_q && !cs_n_q;
      lane_sel = wr_all_n_q ? (wr_lane_en_n_q ? '0 : ~lane_n_q) : '1;
      wreq     = |lane_sel;

      if (sleep_q)               cyc_o = CYC_IDLE;
      else if (proc_go)          cyc_o = selected ? CYC_START : CYC_DESEL;
      else if (!start_ctrl_n_q)  cyc_o = selected ? CYC_START : CYC_DESEL;
      else if (active_i)         cyc_o = adv_n_q ? CYC_SUSP : CYC_CONT;
      else                       cyc_o = CYC_IDLE;

      wr_o = wreq && !(cyc_o == CYC_START && proc_go)
             && (cyc_o == CYC_START || cyc_o == CYC_CONT || cyc_o == CYC_SUSP);
      rd_o = !wr_o && (cyc_o == CYC_START || cyc_o == CYC_CONT || cyc_o == CYC_SUSP);
      lane_we_o = wr_o ? lane_sel : '0;
   end

endmodule

// File: rtl/sbm_burst_addr.sv
module sbm_burst_addr #(
   parameter int ADDR_W  = 4,
   parameter int BURST_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sbm_pkg::cyc_e     cyc_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              linear_i,
   output logic [ADDR_W-1:0] acc_addr_o,
   output logic              active_o
);
   import sbm_pkg::*;

   logic [ADDR_W-1:0]  base_q;
   logic [BURST_W-1:0] cnt_q, cnt_eff, low;
   logic               active_q;

   always_comb begin
      cnt_eff = (cyc_i == CYC_CONT) ? cnt_q + BURST_W'(1) : cnt_q;
      low     = linear_i ? base_q[BURST_W-1:0] + cnt_eff
                         : base_q[BURST_W-1:0] ^ cnt_eff;
      acc_addr_o = (cyc_i == CYC_START) ? addr_i
                                        : {base_q[ADDR_W-1:BURST_W], low};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q   <= '0;
         cnt_q    <= '0;
         active_q <= 1'b0;
      end else begin
         case (cyc_i)
            CYC_START: begin
               base_q   <= addr_i;
               cnt_q    <= '0;
               active_q <= 1'b1;
            end
            CYC_CONT:  cnt_q    <= cnt_eff;
            CYC_SUSP:  cnt_q    <= cnt_q;
            default:   active_q <= 1'b0;
         endcase
      end
   end

   assign active_o = active_q;

endmodule

// File: rtl/sbm_lane_array.sv
module sbm_lane_array #(
   parameter int ADDR_W = 4,
   parameter int LANES  = 4,
   localparam int LB    = sbm_pkg::LANE_BITS,
   localparam int DW    = LANES * LB,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic [LANES-1:0]  we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DW-1:0]     wdata_i,
   output logic [DW-1:0]     rdata_o
);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LB-1:0] cells [DEPTH];

      always_ff @(posedge clk) begin
         if (we_i[g]) cells[addr_i] <= wdata_i[g*LB +: LB];
      end

      assign rdata_o[g*LB +: LB] = cells[addr_i];
   end

endmodule

// File: rtl/burst_sram_core.sv
module burst_sram_core #(
   parameter int ADDR_W  = 4,
   parameter int LANES   = 4,
   parameter int DATA_W  = 32,
   parameter int BURST_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              cs_n_i,
   input  logic              cs2_n_i,
   input  logic              cs2_i,
   input  logic              start_proc_n_i,
   input  logic              start_ctrl_n_i,
   input  logic              adv_n_i,
   input  logic              wr_all_n_i,
   input  logic              wr_lane_en_n_i,
   input  logic [LANES-1:0]  lane_n_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              burst_linear_i,
   input  logic              oe_n_i,
   input  logic              sleep_i,
   output logic [DATA_W-1:0] dq_o,
   output logic              dq_en_o
);
   import sbm_pkg::*;

   if (DATA_W != LANES * LANE_BITS) begin : g_bad_width
      $error("DATA_W must equal LANES times the lane width");
   end
   if (ADDR_W <= BURST_W) begin : g_bad_addr
      $error("ADDR_W must exceed BURST_W");
   end

   logic [ADDR_W-1:0] addr_q, acc_addr;
   logic              cs_n_q, cs2_n_q, cs2_q, sp_n_q, sc_n_q, adv_n_q;
   logic              wa_n_q, wl_n_q, sleep_q, active, wr, rd;
   logic [LANES-1:0]  lane_n_q, lane_we;
   logic [DATA_W-1:0] wdata_q, rdata, out_q;
   logic              out_v;
   cyc_e              cyc;

   sbm_capture #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cap (
      .clk, .rst_n,
      .addr_i, .cs_n_i, .cs2_n_i, .cs2_i, .start_proc_n_i, .start_ctrl_n_i,
      .adv_n_i, .wr_all_n_i, .wr_lane_en_n_i, .lane_n_i, .wdata_i, .sleep_i,
      .addr_q, .cs_n_q, .cs2_n_q, .cs2_q,
      .start_proc_n_q(sp_n_q), .start_ctrl_n_q(sc_n_q), .adv_n_q,
      .wr_all_n_q(wa_n_q), .wr_lane_en_n_q(wl_n_q), .lane_n_q,
      .wdata_q, .sleep_q
   );

   sbm_cycle_decode #(.LANES(LANES)) u_dec (
      .sleep_q, .cs_n_q, .cs2_n_q, .cs2_q,
      .start_proc_n_q(sp_n_q), .start_ctrl_n_q(sc_n_q), .adv_n_q,
      .wr_all_n_q(wa_n_q), .wr_lane_en_n_q(wl_n_q), .lane_n_q,
      .active_i(active), .cyc_o(cyc), .wr_o(wr), .rd_o(rd), .lane_we_o(lane_we)
   );

   sbm_burst_addr #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_addr (
      .clk, .rst_n, .cyc_i(cyc), .addr_i(addr_q), .linear_i(burst_linear_i),
      .acc_addr_o(acc_addr), .active_o(active)
   );

   sbm_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_mem (
      .clk, .we_i(lane_we), .addr_i(acc_addr), .wdata_i(wdata_q), .rdata_o(rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= '0;
         out_v <= 1'b0;
      end else begin
         out_v <= rd;
         if (rd) out_q <= rdata;
      end
   end

   assign dq_en_o = out_v && !oe_n_i && !sleep_i;
   assign dq_o    = dq_en_o ? out_q : '0;

endmodule

// File: rtl/sbm_checker.sv
module sbm_checker #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n_i,
   input logic              cs2_n_i,
   input logic              cs2_i,
   input logic              start_proc_n_i,
   input logic              start_ctrl_n_i,
   input logic              adv_n_i,
   input logic              wr_all_n_i,
   input logic              wr_lane_en_n_i,
   input logic              oe_n_i,
   input logic              sleep_i,
   input logic [DATA_W-1:0] dq_o,
   input logic              dq_en_o
);

   logic [1:0] warm;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            warm <= 2'd0;
      else if (warm != 2'd3) warm <= warm + 2'd1;
   end

   // R1: controller strobe with primary select high is a deselect
   a_r1_desel_undriven: assert property (@(posedge clk) disable iff (!rst_n)
      (warm >= 2'd2 && $past(!start_ctrl_n_i && cs_n_i, 2)) |-> !dq_en_o);

   // R9: a cycle that could only write never drives the bus
   a_r9_write_undriven: assert property (@(posedge clk) disable iff (!rst_n)
      (warm >= 2'd2 && $past(!wr_all_n_i && !(!start_proc_n_i && !cs_n_i), 2))
      |-> !dq_en_o);

   // R2, R7: a selected processor-strobe start drives read data two edges on
   a_r2_proc_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
      (warm >= 2'd2 && $past(!start_proc_n_i && !cs_n_i && !cs2_n_i && cs2_i
                             && !sleep_i, 2) && !oe_n_i && !sleep_i)
      |-> dq_en_o);

   // R4: two back-to-back suspend reads return the same word
   a_r4_suspend_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 2'd3
       && $past(start_proc_n_i && start_ctrl_n_i && adv_n_i && wr_all_n_i
                && wr_lane_en_n_i && !sleep_i, 2)
       && $past(start_proc_n_i && start_ctrl_n_i && adv_n_i && wr_all_n_i
                && wr_lane_en_n_i && !sleep_i, 3)
       && dq_en_o && $past(dq_en_o))
      |-> $stable(dq_o));

endmodule

bind burst_sram_core sbm_checker #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .cs2_n_i(cs2_n_i), .cs2_i(cs2_i),
   .start_proc_n_i(start_proc_n_i), .start_ctrl_n_i(start_ctrl_n_i),
   .adv_n_i(adv_n_i), .wr_all_n_i(wr_all_n_i), .wr_lane_en_n_i(wr_lane_en_n_i),
   .oe_n_i(oe_n_i), .sleep_i(sleep_i), .dq_o(dq_o), .dq_en_o(dq_en_o)
);

// File: tb/burst_sram_core_tb.sv
module burst_sram_core_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  addr_i = '0;
   logic        cs_n_i = 1'b1, cs2_n_i = 1'b0, cs2_i = 1'b1;
   logic        start_proc_n_i = 1'b1, start_ctrl_n_i = 1'b1, adv_n_i = 1'b1;
   logic        wr_all_n_i = 1'b1, wr_lane_en_n_i = 1'b1;
   logic [3:0]  lane_n_i = 4'hF;
   logic [31:0] wdata_i = '0;
   logic        burst_linear_i = 1'b1, oe_n_i = 1'b0, sleep_i = 1'b0;
   logic [31:0] dq_o;
   logic        dq_en_o;

   int checks = 0;
   int failures = 0;
   bit done = 0;
   logic [31:0] mem_m [16];

   always #4 clk = ~clk;

   burst_sram_core u_dut (
      .clk, .rst_n, .addr_i, .cs_n_i, .cs2_n_i, .cs2_i, .start_proc_n_i,
      .start_ctrl_n_i, .adv_n_i, .wr_all_n_i, .wr_lane_en_n_i, .lane_n_i,
      .wdata_i, .burst_linear_i, .oe_n_i, .sleep_i, .dq_o, .dq_en_o
   );

   task automatic chk(input string tag, input logic en_exp, input logic [31:0] d_exp);
      checks++;
      if (dq_en_o !== en_exp || (en_exp && dq_o !== d_exp)) begin
         failures++;
         $display("FAIL %s: en=%0b data=%h expected en=%0b data=%h",
                  tag, dq_en_o, dq_o, en_exp, d_exp);
      end
   endtask

   // one clock step: set inputs, then wait for the next falling edge
   task automatic step(input logic sp, sc, adv, csn, cs2n, cs2, wa, wl,
                       input logic [3:0] ln, input logic [3:0] a, input logic [31:0] d);
      start_proc_n_i = sp; start_ctrl_n_i = sc; adv_n_i = adv;
      cs_n_i = csn; cs2_n_i = cs2n; cs2_i = cs2;
      wr_all_n_i = wa; wr_lane_en_n_i = wl; lane_n_i = ln;
      addr_i = a; wdata_i = d;
      @(negedge clk);
   endtask

   task automatic desel();
      step(1, 0, 1, 1, 0, 1, 1, 1, 4'hF, 4'h0, 32'h0);
   endtask
   task automatic ctrl_rd(input logic [3:0] a);
      step(1, 0, 1, 0, 0, 1, 1, 1, 4'hF, a, 32'h0);
   endtask
   task automatic ctrl_wr(input logic [3:0] a, input logic [31:0] d);
      step(1, 0, 1, 0, 0, 1, 0, 1, 4'hF, a, d);
      mem_m[a] = d;
   endtask
   task automatic proc_rd(input logic [3:0] a);
      step(0, 1, 1, 0, 0, 1, 1, 1, 4'hF, a, 32'h0);
   endtask
   task automatic adv(input logic go);
      step(1, 1, !go, 0, 0, 1, 1, 1, 4'hF, 4'h0, 32'h0);
   endtask
   task automatic rd_chk(input logic [3:0] a, input string tag);
      ctrl_rd(a);
      desel();
      chk(tag, 1'b1, mem_m[a]);
   endtask

   function automatic logic [31:0] pat(input int a, input int s);
      return 32'hA5C3_0000 ^ (32'(a) * 32'h0101_0101) ^ (32'(s) << 4);
   endfunction

   function automatic logic [3:0] beat(input logic [3:0] b, input int n, input bit lin);
      logic [1:0] lo;
      lo = lin ? b[1:0] + 2'(n) : b[1:0] ^ 2'(n);
      return {b[3:2], lo};
   endfunction

   initial begin
      #(8 * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: en=%0b data=%h expected en=x data=x", dq_en_o, dq_o);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R9 reset", 1'b0, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 after reset", 1'b0, 32'h0);

      // R3 write sweep, then read sweep; R9 write leaves bus undriven
      for (int a = 0; a < 16; a++) begin
         ctrl_wr(4'(a), pat(a, 1));
         desel();
         chk("R9 write", 1'b0, 32'h0);
      end
      for (int a = 0; a < 16; a++) rd_chk(4'(a), "R3 R7 read");

      // R5 byte lanes, every lane mask
      for (int m = 0; m < 16; m++) begin
         logic [31:0] d;
         ctrl_wr(4'd3, 32'h0);
         d = 32'h1122_3344 ^ (32'(m) * 32'h0F0F_0F0F);
         step(1, 0, 1, 0, 0, 1, 1, 0, ~4'(m), 4'd3, d);
         for (int k = 0; k < 4; k++) if (m[k]) mem_m[3][k*8 +: 8] = d[k*8 +: 8];
         desel();
         rd_chk(4'd3, "R5 lane mask");
      end
      // R5 lane enable high: lane bits ignored, cycle reads
      step(1, 0, 1, 0, 0, 1, 1, 1, 4'h0, 4'd7, 32'hDEAD_BEEF);
      desel();
      chk("R5 lane enable high reads", 1'b1, mem_m[7]);
      rd_chk(4'd7, "R5 no write");

      // R4 R7 bursts, both orders, every start offset
      for (int lin = 0; lin < 2; lin++) begin
         burst_linear_i = lin[0];
         for (int off = 0; off < 4; off++) begin
            logic [3:0] b;
            b = 4'(4 + 4 * lin + off);
            proc_rd(b);
            adv(1); chk("R7 beat0", 1'b1, mem_m[beat(b, 0, lin[0])]);
            adv(1); chk("R4 beat1", 1'b1, mem_m[beat(b, 1, lin[0])]);
            adv(1); chk("R4 beat2", 1'b1, mem_m[beat(b, 2, lin[0])]);
            desel(); chk("R4 beat3", 1'b1, mem_m[beat(b, 3, lin[0])]);
            desel(); chk("R1 deselect", 1'b0, 32'h0);
         end
      end

      // R4 suspend repeats the current address
      burst_linear_i = 1'b1;
      proc_rd(4'd1);
      adv(1); chk("R4 susp b0", 1'b1, mem_m[1]);
      adv(0); chk("R4 susp b1", 1'b1, mem_m[2]);
      adv(1); chk("R4 susp hold", 1'b1, mem_m[2]);
      desel(); chk("R4 susp b2", 1'b1, mem_m[3]);

      // R2 processor strobe ignored with primary select high
      ctrl_rd(4'd4);
      adv(1); chk("R2 ign b0", 1'b1, mem_m[4]);
      step(0, 1, 0, 1, 0, 1, 1, 1, 4'hF, 4'd12, 32'h0);
      chk("R2 ign b1", 1'b1, mem_m[5]);
      desel(); chk("R2 ign continues", 1'b1, mem_m[6]);

      // R2 processor start with write controls reads; R6 write on continue
      step(0, 1, 1, 0, 0, 1, 0, 1, 4'hF, 4'd9, 32'h7777_7777);
      step(1, 1, 0, 0, 0, 1, 0, 1, 4'hF, 4'd0, 32'hCAFE_0A0A);
      mem_m[10] = 32'hCAFE_0A0A;
      chk("R2 proc start reads", 1'b1, mem_m[9]);
      desel(); chk("R9 R6 write undriven", 1'b0, 32'h0);
      rd_chk(4'd10, "R6 write after proc read");
      rd_chk(4'd9, "R2 no write at start");

      // R1 deselect by an inactive select; later advance does nothing
      ctrl_rd(4'd12);
      step(1, 0, 1, 0, 0, 0, 1, 1, 4'hF, 4'd12, 32'h0);
      chk("R1 before desel", 1'b1, mem_m[12]);
      step(1, 1, 0, 0, 0, 1, 0, 1, 4'hF, 4'd0, 32'h0BAD_0BAD);
      chk("R1 desel undriven", 1'b0, 32'h0);
      desel();
      rd_chk(4'd12, "R1 no access");
      rd_chk(4'd13, "R1 no access");
      step(0, 1, 1, 0, 1, 1, 1, 1, 4'hF, 4'd2, 32'h0);
      desel(); chk("R1 proc desel", 1'b0, 32'h0);

      // R11 read right after write
      ctrl_wr(4'd5, 32'h5A5A_1234);
      ctrl_rd(4'd5);
      desel(); chk("R11 read after write", 1'b1, 32'h5A5A_1234);

      // R8 output enable
      ctrl_rd(4'd8);
      desel();
      oe_n_i = 1'b1; #1; chk("R8 oe high", 1'b0, 32'h0);
      oe_n_i = 1'b0; #1; chk("R8 oe low", 1'b1, mem_m[8]);

      // R10 sleep
      ctrl_rd(4'd11);
      desel(); chk("R10 before sleep", 1'b1, mem_m[11]);
      sleep_i = 1'b1; #1; chk("R10 sleep undriven", 1'b0, 32'h0);
      step(1, 0, 1, 0, 0, 1, 0, 1, 4'hF, 4'd11, 32'hFFFF_0000);
      desel();
      sleep_i = 1'b0;
      desel();
      rd_chk(4'd11, "R10 no write in sleep");

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule